// File: doc/BRIEF.md
# Low-Power Entry Gate with Self-Locking Controls

This block sits between the core and the power controller and decides whether a stop or wait instruction may actually enter its low-power mode. The core raises a one-cycle execute strobe for each instruction. The block holds one 2-bit control field per mode in a single control register, which software writes through a simple write port. When a strobe arrives and the matching field allows entry, the block issues a one-cycle entry request to the power controller on the following clock.

Each field has a disable bit (its low bit) and a lock bit (its high bit). Once the lock bit is set, further writes to that field have no effect until reset. The other field can still be written. Software uses this to fix a policy such as "wait never enters its mode" early in boot, so that later code cannot undo it. The register reads back continuously on a readback bus. Bits above the two fields always read as zero.

Top module: `lpm_entry_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, both fields read 00, `ctrl_rdata` is zero, and neither entry request is asserted.
- R2: A write with `wr_en` high and `wr_addr` equal to `CTRL_ADDR` (default 1) loads `wr_data[1:0]` into the wait field and `wr_data[3:2]` into the stop field, unless that field is locked. The new value is visible on `ctrl_rdata` from the next cycle.
- R3: `ctrl_rdata[DATA_W-1:4]` always reads zero, whatever upper bits were written.
- R4: A write to any address other than `CTRL_ADDR` leaves the register unchanged.
- R5: A `wait_strobe` while wait-field bit 0 is 0 gives `wait_req` high for exactly the one cycle after the strobe.
- R6: A `wait_strobe` while wait-field bit 0 is 1 gives no `wait_req`.
- R7: A `stop_strobe` gives a one-cycle `stop_req` in the next cycle exactly when stop-field bit 2 is 0.
- R8: Once a field's lock bit is 1 (bit 1 for wait, bit 3 for stop), writes leave that field unchanged. Field values 10 and 11 therefore allow or block entry permanently.
- R9: A locked field does not stop writes to the other, unlocked field.
- R10: Only a reset clears a lock. After reset both fields are writable again.
- R11: Entry is decided by the field value held at the clock edge of the strobe. A write in the same cycle as a strobe affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears both fields and locks |
| stop_strobe | input | 1 | One-cycle strobe: core executed a stop instruction |
| wait_strobe | input | 1 | One-cycle strobe: core executed a wait instruction |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| stop_req | output | 1 | One-cycle stop-mode entry request |
| wait_req | output | 1 | One-cycle wait-mode entry request |
| ctrl_rdata | output | DATA_W | Control register readback, upper bits zero |

## Verification
A wrong disable bit shows up on the request of the very next strobe. An entry is granted that should be blocked, or lost when it should be granted, exactly one cycle after the strobe. A lock that fails to hold, or that leaks into the other field, shows on `ctrl_rdata` in the cycle after the offending write. A lock that survives reset shows as a rejected write right after reset. The sweep loads every 4-bit setting and then tries every 4-bit overwrite. It therefore drives each combination of lock and disable on both fields into both of these visible symptoms.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int FIELD_W  = 2;
  localparam int DIS_BIT  = 0;
  localparam int LOCK_BIT = 1;

  typedef logic [FIELD_W-1:0] ctl_field_t;

  typedef enum int {
    MODE_WAIT = 0,
    MODE_STOP = 1
  } lp_mode_e;

  function automatic logic entry_allowed(ctl_field_t f);
    return !f[DIS_BIT];
  endfunction

  function automatic logic field_locked(ctl_field_t f);
    return f[LOCK_BIT];
  endfunction

  function automatic ctl_field_t field_next(ctl_field_t cur, ctl_field_t wval, logic we);
    if (we && !field_locked(cur)) return wval;
    return cur;
  endfunction
endpackage

// File: rtl/lpg_field.sv
module lpg_field
  import lpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  ctl_field_t wr_val,
  output ctl_field_t field_q,
  output logic       allow,
  output logic       locked
);
  ctl_field_t field_d;

  always_comb field_d = field_next(field_q, wr_val, wr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) field_q <= '0;
    else        field_q <= field_d;
  end

  assign allow  = entry_allowed(field_q);
  assign locked = field_locked(field_q);

  assert_lock_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(field_q));

  assert_unlocked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !locked) |=> (field_q == $past(wr_val)));
endmodule

// File: rtl/lpg_req.sv
module lpg_req (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic allow,
  output logic req_q
);
  logic grant;

  assign grant = strobe && allow;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= grant;
  end

  assert_blocked_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !allow) |=> !req_q);

  assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(strobe));
endmodule

// File: rtl/lpm_entry_gate.sv
module lpm_entry_gate
  import lpg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_strobe,
  input  logic              wait_strobe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stop_req,
  output logic              wait_req,
  output logic [DATA_W-1:0] ctrl_rdata
);
  localparam int NUM_MODES = 2;
  localparam int USED_W    = NUM_MODES * FIELD_W;

  logic                 wr_hit;
  logic [NUM_MODES-1:0] strobe_vec;
  logic [NUM_MODES-1:0] allow_vec;
  logic [NUM_MODES-1:0] lock_vec;
  logic [NUM_MODES-1:0] req_vec;
  logic [USED_W-1:0]    fields_flat;
  logic                 unused_wdata_hi;

  assign wr_hit          = wr_en && (wr_addr == CTRL_ADDR);
  assign unused_wdata_hi = ^wr_data[DATA_W-1:USED_W];

  assign strobe_vec[MODE_WAIT] = wait_strobe;
  assign strobe_vec[MODE_STOP] = stop_strobe;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    ctl_field_t fq;

    lpg_field u_field (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wr_val (wr_data[m*FIELD_W +: FIELD_W]),
      .field_q(fq),
      .allow  (allow_vec[m]),
      .locked (lock_vec[m])
    );

    assign fields_flat[m*FIELD_W +: FIELD_W] = fq;

    lpg_req u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(strobe_vec[m]),
      .allow (allow_vec[m]),
      .req_q (req_vec[m])
    );
  end

  assign wait_req   = req_vec[MODE_WAIT];
  assign stop_req   = req_vec[MODE_STOP];
  assign ctrl_rdata = {{(DATA_W-USED_W){1'b0}}, fields_flat};

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[DATA_W-1:USED_W] == '0);

  assert_other_addr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != CTRL_ADDR) |=> $stable(ctrl_rdata));

  assert_stop_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_strobe |=> (stop_req == !$past(ctrl_rdata[2])));

  assert_lock_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && lock_vec[MODE_STOP] && !lock_vec[MODE_WAIT])
      |=> (ctrl_rdata[1:0] == $past(wr_data[1:0])));
endmodule

// File: tb/lpm_entry_gate_bench.sv
module lpm_entry_gate_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] CA = 4'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_strobe = 1'b0, wait_strobe = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic stop_req, wait_req;
  logic [DATA_W-1:0] ctrl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_entry_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CA)) u_lpm_entry_gate (
    .clk(clk), .rst_n(rst_n), .stop_strobe(stop_strobe), .wait_strobe(wait_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_req(stop_req), .wait_req(wait_req), .ctrl_rdata(ctrl_rdata));

  logic [3:0] model;

  function automatic logic [1:0] upd(logic [1:0] cur, logic [1:0] nv);
    return (cur >= 2'd2) ? cur : nv;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; stop_strobe = 1'b0; wait_strobe = 1'b0;
    @(negedge clk);
    chk("R1 rdata in reset", ctrl_rdata, 0);
    chk("R1 req in reset", {stop_req, wait_req}, 0);
    rst_n = 1'b1;
    model = 4'h0;
    @(negedge clk);
    chk("R1 rdata after reset", ctrl_rdata, 0);
    chk("R1 req after reset", {stop_req, wait_req}, 0);
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == CA)
      model = {upd(model[3:2], d[3:2]), upd(model[1:0], d[1:0])};
  endtask

  task automatic strobe_both(string tag);
    stop_strobe = 1'b1; wait_strobe = 1'b1;
    @(negedge clk);
    stop_strobe = 1'b0; wait_strobe = 1'b0;
    chk({tag, " R5/R6 wait_req"}, wait_req, !model[0]);
    chk({tag, " R7 stop_req"}, stop_req, !model[2]);
    @(negedge clk);
    chk({tag, " R5 single pulse"}, {stop_req, wait_req}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        // R2 R3: first write always lands; garbage in upper bits
        do_write(CA, 16'(a) | 16'hA5F0);
        chk("R2 first write", ctrl_rdata, a);
        chk("R3 upper zero", ctrl_rdata[15:4], 0);
        strobe_both("first");
        // R8 R9: overwrite obeys per-field lock
        do_write(CA, 16'(b) | 16'h5A00);
        chk("R8/R9 overwrite", ctrl_rdata, model);
        strobe_both("second");
      end
    end

    // R10: reset clears a full lock
    do_reset();
    do_write(CA, 16'h000F);
    do_write(CA, 16'h0000);
    chk("R8 locked stays", ctrl_rdata, 16'h000F);
    do_reset();
    do_write(CA, 16'h0005);
    chk("R10 writable after reset", ctrl_rdata, 16'h0005);

    // R4: other addresses ignored
    do_reset();
    for (int x = 0; x < 16; x++) begin
      if (x == CA) continue;
      do_write(ADDR_W'(x), 16'hFFFF);
      chk("R4 other address", ctrl_rdata, 0);
    end
    strobe_both("R4");

    // R11: strobe together with blocking write uses old value
    do_reset();
    wait_strobe = 1'b1; stop_strobe = 1'b1;
    wr_en = 1'b1; wr_addr = CA; wr_data = 16'h0005;
    @(negedge clk);
    wait_strobe = 1'b0; stop_strobe = 1'b0; wr_en = 1'b0;
    chk("R11 wait old value", wait_req, 1'b1);
    chk("R11 stop old value", stop_req, 1'b1);
    chk("R11 write landed", ctrl_rdata, 16'h0005);
    model = 4'h5;
    @(negedge clk);
    strobe_both("R11 later");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule